// File: doc/BRIEF.md
# Sequential Divider with Condition-Flag Rules

This block performs integer division for a processor's word and long divide instructions. It produces one quotient bit per clock cycle. Three forms are supported. The first divides a 32-bit dividend by a 16-bit divisor and packs the remainder and quotient into a single destination word. The second divides a 32-bit dividend by a 32-bit divisor. The third divides a 64-bit dividend, taken from a register pair, by a 32-bit divisor. Each form can run as signed or unsigned. Signed division truncates toward zero, and the remainder takes the sign of the dividend.

The surrounding pipeline supplies the operand values, the form, the signedness and a start strobe. In return it receives the destination values with their write enables, the N/Z/V/C flags and a divide-by-zero trap strobe. A single-cycle `done_o` marks the completion of every operation.

Inside, a state machine runs through four states:
- `ST_IDLE` waits for `start_i`.
- `ST_CALC` performs one restoring step per cycle. It runs W steps for the short forms and 2W steps for the register-pair form.
- `ST_SETTLE` applies the signs, tests for overflow and registers the results.
- `ST_REPORT` presents `done_o` for one cycle.

The transitions are:
- idle-to-calc: start with a non-zero divisor.
- idle-to-report: start with a zero divisor, which raises the trap.
- calc-to-settle: after the last step.
- settle-to-report: always.
- report-to-idle: always.

Top module: `flagdiv_seq`

## Requirements
- R1: `form_i` selects the form. The value 0 is 32/16: the dividend is `dvd_lo_i` and the divisor is `dvs_i[W/2-1:0]`. The value 1 is 32/32: the dividend is `dvd_lo_i` and the divisor is `dvs_i`. The value 2 is 64/32: the dividend is {`dvd_hi_i`,`dvd_lo_i`}, where `dvd_hi_i` is the remainder register's value and `dvd_lo_i` is the quotient register's value. The value 3 behaves as 1. When `signed_i` is 1, all operands are two's complement.
- R2: A successful 32/16 division sets `quo_val_o` = {remainder[W/2-1:0], quotient[W/2-1:0]} with `quo_we_o`=1 and `rem_we_o`=0. N is quotient bit W/2-1, Z is set when the W/2-bit quotient is zero, and V is 0.
- R3: In the 32/16 form, overflow occurs when the unsigned quotient needs more than W/2 bits, or when the signed quotient lies outside the W/2-bit two's complement range. On overflow, V=1 and Z=1, N keeps its previous value, and both write enables stay 0.
- R4: A successful 32/32 or 64/32 division sets `quo_val_o` to the W-bit quotient and `rem_val_o` to the W-bit remainder, with `quo_we_o`=1. `rem_we_o`=1 unless `same_dest_i`=1, in which case only the quotient is written. N and Z come from the W-bit quotient, and V is 0.
- R5: In the 32/32 and 64/32 forms, overflow occurs when the quotient does not fit in W bits, unsigned or signed as selected (for example, the most negative value divided by -1). Overflow follows the same flag and no-write rule as R3.
- R6: Signed quotients truncate toward zero, and a non-zero remainder carries the sign of the dividend.
- R7: `flag_c_o` reads 0 after every completion, including overflow and divide by zero.
- R8: A divisor that is zero within its form's width raises `dz_trap_o` together with `done_o` on the first edge after the start. Neither write enable is raised, and N, Z and V keep their values.
- R9: The cycle count is measured from the edge that samples `start_i`, counting that edge as the first. `done_o` goes high after exactly W+2 edges for forms 0, 1 and 3, and after 2W+2 edges for form 2. `busy_o` is high from the first edge until `done_o` rises, and `done_o` lasts one cycle.
- R10: `start_i` is ignored outside `ST_IDLE`. The running operation completes with its original operands.
- R11: After reset, `done_o`, `busy_o`, `dz_trap_o`, both write enables and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begins an operation when idle |
| form_i | input | 2 | Division form (R1) |
| signed_i | input | 1 | Two's complement operands when 1 |
| same_dest_i | input | 1 | Quotient and remainder name one register |
| dvd_hi_i | input | W | Upper dividend half (64/32 form only) |
| dvd_lo_i | input | W | Dividend, or its lower half |
| dvs_i | input | W | Divisor |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion strobe |
| dz_trap_o | output | 1 | Divide-by-zero trap strobe |
| quo_we_o | output | 1 | Write enable for the quotient destination |
| quo_val_o | output | W | Quotient destination value |
| rem_we_o | output | 1 | Write enable for the remainder destination |
| rem_val_o | output | W | Remainder destination value |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |
| flag_v_o | output | 1 | Overflow flag |
| flag_c_o | output | 1 | Carry flag |

## Verification
The bench builds the block at its default width W=32, so the half-width form works on 16-bit fields. At this width the exact boundaries can be exercised: -32768 versus +32768 in the short signed form, the most negative 32-bit value divided by -1, and 64-bit dividends whose quotient is exactly 2^31 or 2^32. The register-pair form takes 66 edges and the short forms take 34, which keeps the latency checks brief. A chain of overflow and divide-by-zero cases, each following a result whose N differs, shows that the flags are held rather than recomputed.

// File: rtl/divflag_pkg.sv
package divflag_pkg;

    typedef enum logic [1:0] {
        FORM_W16  = 2'd0,
        FORM_L32  = 2'd1,
        FORM_Q64  = 2'd2,
        FORM_L32B = 2'd3
    } div_form_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CALC,
        ST_SETTLE,
        ST_REPORT
    } div_state_e;

endpackage

// File: rtl/divflag_prep.sv
// Operand conditioning: sign extension, magnitudes, zero-divisor detect.
module divflag_prep #(
    parameter int W = 32
) (
    input  logic [1:0]     form_i,
    input  logic           signed_i,
    input  logic [W-1:0]   dvd_hi_i,
    input  logic [W-1:0]   dvd_lo_i,
    input  logic [W-1:0]   dvs_i,
    output logic [2*W-1:0] dvd_aligned_o,
    output logic [W-1:0]   dvs_mag_o,
    output logic           q_neg_o,
    output logic           r_neg_o,
    output logic           wide_o,
    output logic           word_o,
    output logic           dz_o
);
    import divflag_pkg::*;
    localparam int HW = W / 2;

    logic [W-1:0]   dvs_ext;
    logic [2*W-1:0] dvd_full;
    logic [2*W-1:0] dvd_mag;
    logic           dvs_neg;
    logic           dvd_neg;

    always_comb begin
        wide_o = (div_form_e'(form_i) == FORM_Q64);
        word_o = (div_form_e'(form_i) == FORM_W16);

        if (word_o)
            dvs_ext = {{HW{signed_i & dvs_i[HW-1]}}, dvs_i[HW-1:0]};
        else
            dvs_ext = dvs_i;
        dvs_neg   = signed_i & dvs_ext[W-1];
        dvs_mag_o = dvs_neg ? (~dvs_ext + 1'b1) : dvs_ext;
        dz_o      = (dvs_ext == '0);

        if (wide_o)
            dvd_full = {dvd_hi_i, dvd_lo_i};
        else
            dvd_full = {{W{signed_i & dvd_lo_i[W-1]}}, dvd_lo_i};
        dvd_neg = signed_i & dvd_full[2*W-1];
        dvd_mag = dvd_neg ? (~dvd_full + 1'b1) : dvd_full;

        // short forms run only W steps, so their dividend sits in the top half
        dvd_aligned_o = wide_o ? dvd_mag : {dvd_mag[W-1:0], {W{1'b0}}};

        q_neg_o = dvd_neg ^ dvs_neg;
        r_neg_o = dvd_neg;
    end
endmodule

// File: rtl/divflag_core.sv
// Restoring shift/subtract engine, one quotient bit per step.
module divflag_core #(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load_i,
    input  logic           step_i,
    input  logic           wide_i,
    input  logic [2*W-1:0] dvd_i,
    input  logic [W-1:0]   dvs_i,
    output logic           last_o,
    output logic [2*W-1:0] quot_o,
    output logic [W-1:0]   rem_o
);
    localparam int CW = $clog2(2 * W);

    logic [2*W-1:0] q_q;
    logic [W-1:0]   r_q;
    logic [W-1:0]   d_q;
    logic [CW-1:0]  cnt_q;
    logic [CW-1:0]  lim_q;

    logic [W:0]     trial;
    logic [W:0]     diff;
    logic           fits;
    logic [W-1:0]   r_next;

    always_comb begin
        trial  = {r_q, q_q[2*W-1]};
        diff   = trial - {1'b0, d_q};
        fits   = (trial >= {1'b0, d_q});
        r_next = fits ? diff[W-1:0] : trial[W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q   <= '0;
            r_q   <= '0;
            d_q   <= '0;
            cnt_q <= '0;
            lim_q <= '0;
        end else if (load_i) begin
            q_q   <= dvd_i;
            r_q   <= '0;
            d_q   <= dvs_i;
            cnt_q <= '0;
            lim_q <= wide_i ? CW'(2 * W - 1) : CW'(W - 1);
        end else if (step_i) begin
            q_q   <= {q_q[2*W-2:0], fits};
            r_q   <= r_next;
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last_o = (cnt_q == lim_q);
    assign quot_o = q_q;
    assign rem_o  = r_q;
endmodule

// File: rtl/divflag_pack.sv
// Sign application, range test and destination packing.
module divflag_pack #(
    parameter int W = 32
) (
    input  logic           word_i,
    input  logic           signed_i,
    input  logic           q_neg_i,
    input  logic           r_neg_i,
    input  logic [2*W-1:0] qmag_i,
    input  logic [W-1:0]   rmag_i,
    output logic           ovf_o,
    output logic [W-1:0]   res_q_o,
    output logic [W-1:0]   res_r_o,
    output logic           n_o,
    output logic           z_o
);
    localparam int HW = W / 2;

    logic           ovf_half;
    logic           ovf_full;
    logic [2*W-1:0] q_sig;
    logic [W-1:0]   r_sig;

    always_comb begin
        ovf_half = (|qmag_i[2*W-1:HW]) |
                   (signed_i & (q_neg_i ? (qmag_i[HW-1] & (|qmag_i[HW-2:0]))
                                        : qmag_i[HW-1]));
        ovf_full = (|qmag_i[2*W-1:W]) |
                   (signed_i & (q_neg_i ? (qmag_i[W-1] & (|qmag_i[W-2:0]))
                                        : qmag_i[W-1]));
        ovf_o = word_i ? ovf_half : ovf_full;

        q_sig = q_neg_i ? (~qmag_i + 1'b1) : qmag_i;
        r_sig = r_neg_i ? (~rmag_i + 1'b1) : rmag_i;

        if (word_i) begin
            res_q_o = {r_sig[HW-1:0], q_sig[HW-1:0]};
            res_r_o = r_sig;
            n_o     = q_sig[HW-1];
            z_o     = (q_sig[HW-1:0] == '0);
        end else begin
            res_q_o = q_sig[W-1:0];
            res_r_o = r_sig;
            n_o     = q_sig[W-1];
            z_o     = (q_sig[W-1:0] == '0);
        end
    end
endmodule

// File: rtl/flagdiv_seq.sv
module flagdiv_seq #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [1:0]   form_i,
    input  logic         signed_i,
    input  logic         same_dest_i,
    input  logic [W-1:0] dvd_hi_i,
    input  logic [W-1:0] dvd_lo_i,
    input  logic [W-1:0] dvs_i,
    output logic         busy_o,
    output logic         done_o,
    output logic         dz_trap_o,
    output logic         quo_we_o,
    output logic [W-1:0] quo_val_o,
    output logic         rem_we_o,
    output logic [W-1:0] rem_val_o,
    output logic         flag_n_o,
    output logic         flag_z_o,
    output logic         flag_v_o,
    output logic         flag_c_o
);
    import divflag_pkg::*;

    div_state_e state_q, state_d;

    logic [2*W-1:0] pre_dvd;
    logic [W-1:0]   pre_dvs;
    logic           pre_qneg, pre_rneg, pre_wide, pre_word, pre_dz;
    logic           accept;

    logic           ctx_word, ctx_sgn, ctx_qneg, ctx_rneg, ctx_same;

    logic           core_last;
    logic [2*W-1:0] core_quot;
    logic [W-1:0]   core_rem;

    logic           pk_ovf, pk_n, pk_z;
    logic [W-1:0]   pk_q, pk_r;

    divflag_prep #(.W(W)) prep_i (
        .form_i        (form_i),
        .signed_i      (signed_i),
        .dvd_hi_i      (dvd_hi_i),
        .dvd_lo_i      (dvd_lo_i),
        .dvs_i         (dvs_i),
        .dvd_aligned_o (pre_dvd),
        .dvs_mag_o     (pre_dvs),
        .q_neg_o       (pre_qneg),
        .r_neg_o       (pre_rneg),
        .wide_o        (pre_wide),
        .word_o        (pre_word),
        .dz_o          (pre_dz)
    );

    assign accept = (state_q == ST_IDLE) && start_i && !pre_dz;

    divflag_core #(.W(W)) core_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (accept),
        .step_i (state_q == ST_CALC),
        .wide_i (pre_wide),
        .dvd_i  (pre_dvd),
        .dvs_i  (pre_dvs),
        .last_o (core_last),
        .quot_o (core_quot),
        .rem_o  (core_rem)
    );

    divflag_pack #(.W(W)) pack_i (
        .word_i   (ctx_word),
        .signed_i (ctx_sgn),
        .q_neg_i  (ctx_qneg),
        .r_neg_i  (ctx_rneg),
        .qmag_i   (core_quot),
        .rmag_i   (core_rem),
        .ovf_o    (pk_ovf),
        .res_q_o  (pk_q),
        .res_r_o  (pk_r),
        .n_o      (pk_n),
        .z_o      (pk_z)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = pre_dz ? ST_REPORT : ST_CALC;
            ST_CALC:   if (core_last) state_d = ST_SETTLE;
            ST_SETTLE: state_d = ST_REPORT;
            ST_REPORT: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // operation context captured at acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_word <= 1'b0;
            ctx_sgn  <= 1'b0;
            ctx_qneg <= 1'b0;
            ctx_rneg <= 1'b0;
            ctx_same <= 1'b0;
        end else if (accept) begin
            ctx_word <= pre_word;
            ctx_sgn  <= signed_i;
            ctx_qneg <= pre_qneg;
            ctx_rneg <= pre_rneg;
            ctx_same <= same_dest_i;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_o    <= 1'b0;
            dz_trap_o <= 1'b0;
            quo_we_o  <= 1'b0;
            rem_we_o  <= 1'b0;
            quo_val_o <= '0;
            rem_val_o <= '0;
            flag_n_o  <= 1'b0;
            flag_z_o  <= 1'b0;
            flag_v_o  <= 1'b0;
        end else begin
            done_o    <= 1'b0;
            dz_trap_o <= 1'b0;
            quo_we_o  <= 1'b0;
            rem_we_o  <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i && pre_dz) begin
                        done_o    <= 1'b1;
                        dz_trap_o <= 1'b1;
                    end
                end
                ST_SETTLE: begin
                    done_o <= 1'b1;
                    if (pk_ovf) begin
                        flag_v_o <= 1'b1;
                        flag_z_o <= 1'b1;
                    end else begin
                        flag_v_o  <= 1'b0;
                        flag_n_o  <= pk_n;
                        flag_z_o  <= pk_z;
                        quo_we_o  <= 1'b1;
                        quo_val_o <= pk_q;
                        if (!ctx_word) begin
                            rem_val_o <= pk_r;
                            rem_we_o  <= !ctx_same;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign busy_o   = (state_q == ST_CALC) || (state_q == ST_SETTLE);
    assign flag_c_o = 1'b0;

endmodule

// File: rtl/flagdiv_seq_chk.sv
module flagdiv_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic busy_o,
    input logic done_o,
    input logic dz_trap_o,
    input logic quo_we_o,
    input logic rem_we_o,
    input logic flag_n_o,
    input logic flag_z_o,
    input logic flag_v_o
);
    AST_DZ_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        dz_trap_o |-> (done_o && !quo_we_o && !rem_we_o)); // R8

    AST_OVF_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && flag_v_o) |-> (!quo_we_o && !rem_we_o)); // R3

    AST_OVF_Z_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && flag_v_o) |-> flag_z_o); // R5

    AST_OVF_N_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && flag_v_o && !dz_trap_o) |-> (flag_n_o == $past(flag_n_o))); // R3

    AST_DZ_FLAGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        dz_trap_o |-> $stable({flag_n_o, flag_z_o, flag_v_o})); // R8

    AST_FLAGS_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable({flag_n_o, flag_z_o, flag_v_o})); // R11

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R9

    AST_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R9

    AST_REM_NEEDS_QUO: assert property (@(posedge clk) disable iff (!rst_n)
        rem_we_o |-> quo_we_o); // R4

    AST_WE_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        quo_we_o |-> done_o); // R2
endmodule

bind flagdiv_seq flagdiv_seq_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .dz_trap_o (dz_trap_o),
    .quo_we_o  (quo_we_o),
    .rem_we_o  (rem_we_o),
    .flag_n_o  (flag_n_o),
    .flag_z_o  (flag_z_o),
    .flag_v_o  (flag_v_o)
);

// File: tb/flagdiv_seq_tb_top.sv
module flagdiv_seq_tb_top;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [1:0]   form_i = 2'd0;
    logic         signed_i = 1'b0;
    logic         same_dest_i = 1'b0;
    logic [W-1:0] dvd_hi_i = '0;
    logic [W-1:0] dvd_lo_i = '0;
    logic [W-1:0] dvs_i = '0;
    logic         busy_o, done_o, dz_trap_o, quo_we_o, rem_we_o;
    logic [W-1:0] quo_val_o, rem_val_o;
    logic         flag_n_o, flag_z_o, flag_v_o, flag_c_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    flagdiv_seq #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .form_i(form_i),
        .signed_i(signed_i), .same_dest_i(same_dest_i),
        .dvd_hi_i(dvd_hi_i), .dvd_lo_i(dvd_lo_i), .dvs_i(dvs_i),
        .busy_o(busy_o), .done_o(done_o), .dz_trap_o(dz_trap_o),
        .quo_we_o(quo_we_o), .quo_val_o(quo_val_o),
        .rem_we_o(rem_we_o), .rem_val_o(rem_val_o),
        .flag_n_o(flag_n_o), .flag_z_o(flag_z_o),
        .flag_v_o(flag_v_o), .flag_c_o(flag_c_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive_ops(input logic [1:0] f, input logic s,
                             input logic [31:0] hi, input logic [31:0] lo,
                             input logic [31:0] dv, input logic same);
        form_i = f; signed_i = s; dvd_hi_i = hi; dvd_lo_i = lo;
        dvs_i = dv; same_dest_i = same;
    endtask

    // Start one operation, wait for done, check every output.
    task automatic run_op(input string req,
                          input logic [1:0] f, input logic s,
                          input logic [31:0] hi, input logic [31:0] lo,
                          input logic [31:0] dv, input logic same,
                          input int exp_lat, input logic exp_dz,
                          input logic exp_qwe, input logic exp_rwe,
                          input logic [31:0] exp_q, input logic [31:0] exp_r,
                          input logic en, input logic ez, input logic ev);
        int  lat;
        bit  seen;
        @(negedge clk);
        drive_ops(f, s, hi, lo, dv, same);
        start_i = 1'b1;
        lat = 0;
        seen = 0;
        for (int i = 0; i < 200; i++) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            start_i = 1'b0;
            if (i == 0 && !exp_dz) chk("R9", "busy after start", 64'(busy_o), 64'd1);
            if (done_o) begin seen = 1; break; end
        end
        if (!seen) begin
            n_tests++; n_fail++;
            $display("FAIL %s done never rose: actual 0 expected 1", req);
        end else begin
            chk("R9", {req, " latency"}, 64'(lat), 64'(exp_lat));
            chk("R9", {req, " busy at done"}, 64'(busy_o), 64'd0);
            chk(req, "dz_trap", 64'(dz_trap_o), 64'(exp_dz));
            chk(req, "quo_we", 64'(quo_we_o), 64'(exp_qwe));
            chk(req, "rem_we", 64'(rem_we_o), 64'(exp_rwe));
            if (exp_qwe) chk(req, "quo_val", 64'(quo_val_o), 64'(exp_q));
            if (exp_rwe) chk(req, "rem_val", 64'(rem_val_o), 64'(exp_r));
            chk(req, "N", 64'(flag_n_o), 64'(en));
            chk(req, "Z", 64'(flag_z_o), 64'(ez));
            chk(req, "V", 64'(flag_v_o), 64'(ev));
            chk("R7", {req, " C"}, 64'(flag_c_o), 64'd0);
        end
        @(negedge clk);
    endtask

    // R11 reset state
    task automatic t_reset;
        chk("R11", "done", 64'(done_o), 0);
        chk("R11", "busy", 64'(busy_o), 0);
        chk("R11", "dz_trap", 64'(dz_trap_o), 0);
        chk("R11", "we", 64'({quo_we_o, rem_we_o}), 0);
        chk("R11", "flags", 64'({flag_n_o, flag_z_o, flag_v_o, flag_c_o}), 0);
    endtask

    // R2 unsigned 32/16: 100000/7
    task automatic t_word_unsigned;
        run_op("R2", 2'd0, 0, 0, 32'd100000, 32'd7, 0, 34, 0, 1, 0,
               {16'(100000 % 7), 16'(100000 / 7)}, 0, 0, 0, 0);
    endtask

    // R6 signed 32/16: -100/7 -> q -14, r -2
    task automatic t_word_signed;
        run_op("R6", 2'd0, 1, 0, 32'hFFFF_FF9C, 32'd7, 0, 34, 0, 1, 0,
               32'hFFFE_FFF2, 0, 1, 0, 0);
    endtask

    // R3 unsigned 32/16 overflow, N held at 1
    task automatic t_word_ovf_unsigned_n1;
        run_op("R3", 2'd0, 0, 0, 32'h0010_0000, 32'd1, 0, 34, 0, 0, 0,
               0, 0, 1, 1, 1);
    endtask

    // R3 signed boundary: -32768/1 fits
    task automatic t_word_signed_min;
        run_op("R3", 2'd0, 1, 0, 32'hFFFF_8000, 32'd1, 0, 34, 0, 1, 0,
               32'h0000_8000, 0, 1, 0, 0);
    endtask

    // R3 signed boundary: +32768/1 overflows
    task automatic t_word_signed_ovf;
        run_op("R3", 2'd0, 1, 0, 32'h0000_8000, 32'd1, 0, 34, 0, 0, 0,
               0, 0, 1, 1, 1);
    endtask

    // R2 zero quotient sets Z
    task automatic t_word_zero;
        run_op("R2", 2'd0, 0, 0, 32'd0, 32'd5, 0, 34, 0, 1, 0,
               0, 0, 0, 1, 0);
    endtask

    // R3 overflow with N held at 0
    task automatic t_word_ovf_n0;
        run_op("R3", 2'd0, 0, 0, 32'h0001_0000, 32'd1, 0, 34, 0, 0, 0,
               0, 0, 0, 1, 1);
    endtask

    // R4 unsigned 32/32 with separate registers
    task automatic t_long_unsigned;
        run_op("R4", 2'd1, 0, 0, 32'hFFFF_FFFF, 32'd16, 0, 34, 0, 1, 1,
               32'h0FFF_FFFF, 32'd15, 0, 0, 0);
    endtask

    // R4 + R6 signed 32/32, same register: quotient wins (form 3 alias, R1)
    task automatic t_long_same_dest;
        run_op("R4", 2'd3, 1, 0, 32'hFFFF_FFF9, 32'd2, 1, 34, 0, 1, 0,
               32'hFFFF_FFFD, 0, 1, 0, 0);
    endtask

    // R5 most negative / -1 in 32/32
    task automatic t_long_ovf;
        run_op("R5", 2'd1, 1, 0, 32'h8000_0000, 32'hFFFF_FFFF, 0, 34, 0, 0, 0,
               0, 0, 1, 1, 1);
    endtask

    // R1 64/32 unsigned: 2^32/2 = 2^31 fits
    task automatic t_quad_unsigned;
        run_op("R1", 2'd2, 0, 32'd1, 32'd0, 32'd2, 0, 66, 0, 1, 1,
               32'h8000_0000, 0, 1, 0, 0);
    endtask

    // R5 64/32 unsigned: 2^33/2 overflows
    task automatic t_quad_ovf_unsigned;
        run_op("R5", 2'd2, 0, 32'd2, 32'd0, 32'd2, 0, 66, 0, 0, 0,
               0, 0, 1, 1, 1);
    endtask

    // R6 64/32 signed: -100/7
    task automatic t_quad_signed;
        run_op("R6", 2'd2, 1, 32'hFFFF_FFFF, 32'hFFFF_FF9C, 32'd7, 0, 66, 0, 1, 1,
               32'hFFFF_FFF2, 32'hFFFF_FFFE, 1, 0, 0);
    endtask

    // R5 64/32 signed: 2^31/1 does not fit
    task automatic t_quad_ovf_signed;
        run_op("R5", 2'd2, 1, 32'd0, 32'h8000_0000, 32'd1, 0, 66, 0, 0, 0,
               0, 0, 1, 1, 1);
    endtask

    // R8 zero divisor after overflow: N,Z,V stay 1,1,1
    task automatic t_quad_dz;
        run_op("R8", 2'd2, 0, 32'd5, 32'd5, 32'd0, 0, 1, 1, 0, 0,
               0, 0, 1, 1, 1);
    endtask

    // R6 signed 100 / -7 -> q -14, r +2
    task automatic t_quad_pos_rem;
        run_op("R6", 2'd2, 1, 32'd0, 32'd100, 32'hFFFF_FFF9, 0, 66, 0, 1, 1,
               32'hFFFF_FFF2, 32'd2, 1, 0, 0);
    endtask

    // R8 word form divisor zero in its low half only
    task automatic t_word_dz;
        run_op("R8", 2'd0, 0, 0, 32'd1234, 32'h0001_0000, 0, 1, 1, 0, 0,
               0, 0, 1, 0, 0);
    endtask

    // R10 start during busy is ignored
    task automatic t_start_while_busy;
        int  lat;
        bit  seen;
        @(negedge clk);
        drive_ops(2'd1, 0, 0, 32'd1000, 32'd10, 0);
        start_i = 1'b1;
        lat = 0;
        seen = 0;
        for (int i = 0; i < 200; i++) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            start_i = (i == 3);
            if (i == 3) drive_ops(2'd0, 1, 0, 32'd7, 32'd0, 1);
            if (done_o) begin seen = 1; break; end
        end
        start_i = 1'b0;
        chk("R10", "done seen", 64'(seen), 64'd1);
        chk("R10", "latency", 64'(lat), 64'd34);
        chk("R10", "dz_trap", 64'(dz_trap_o), 64'd0);
        chk("R10", "quo_val", 64'(quo_val_o), 64'd100);
        chk("R10", "rem_we", 64'(rem_we_o), 64'd1);
        chk("R10", "rem_val", 64'(rem_val_o), 64'd0);
        @(negedge clk);
        chk("R10", "no second done", 64'(done_o), 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_word_unsigned();
        t_word_signed();
        t_word_ovf_unsigned_n1();
        t_word_signed_min();
        t_word_signed_ovf();
        t_word_zero();
        t_word_ovf_n0();
        t_long_unsigned();
        t_long_same_dest();
        t_long_ovf();
        t_quad_unsigned();
        t_quad_ovf_unsigned();
        t_quad_signed();
        t_quad_ovf_signed();
        t_quad_dz();
        t_quad_pos_rem();
        t_word_dz();
        t_start_while_busy();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule